// File: doc/BRIEF.md
# Interframe Gap Deferral Timer

This block decides the moment an Ethernet transmitter is allowed to begin a new frame. It times the quiet interval that must separate frames on the medium, counting in units of a one-cycle bit-time tick, so the same logic serves every line rate. When the interval has run out and the client has a frame waiting, it raises a transmit-permit flag. Until then it holds a defer flag.

In half-duplex operation the block follows the carrier-sense signal from the PHY. It holds off while carrier is present and starts the gap when carrier drops. The gap has two parts. A carrier that reappears in the early, resettable part makes the timer start again from zero. A carrier that reappears in the late part is ignored, so the station still gets its turn. In full-duplex operation carrier sense plays no part at all. The gap then starts when the block's own frame ends, and its length comes from a configuration input. After reset, and after every frame the block itself sends, one complete gap must elapse before the next grant.

The carrier input passes through a synchronizer before use. Both outputs are registered.

Top module: `ifg_defer_timer`

## Requirements
- R1: While reset is high and on leaving reset, `defer` is 1 and `tx_permit` is 0. No permit is given until one full gap has elapsed (`HALF_GAP` = 96 ticks in half-duplex mode).
- R2: `tx_permit` is 1 only when the gap is complete and `frame_pending` is 1. With the gap complete and no frame pending, `tx_permit` is 0 and `defer` is 0.
- R3: In half-duplex mode (`full_duplex` = 0), while carrier is present, `defer` stays 1 and `tx_permit` stays 0, however many ticks arrive.
- R4: In half-duplex mode the gap starts when carrier falls and completes after exactly `HALF_GAP` ticks. Clock cycles without `bit_tick` do not advance the gap.
- R5: If carrier rises while fewer than `part1_len` ticks of the gap have been counted, the gap restarts from zero when carrier falls again.
- R6: If carrier rises after `part1_len` or more ticks have been counted, the gap is not restarted and completes on its original count.
- R7: With `part1_len` = 0, no part of the gap can be restarted by carrier.
- R8: A `tx_begin` pulse while `tx_permit` is 1 clears `tx_permit` and sets `defer`. Both stay that way until `tx_done`, which starts a new gap.
- R9: In full-duplex mode (`full_duplex` = 1), the gap after `tx_done` lasts exactly `gap_len` ticks.
- R10: In full-duplex mode, carrier sense has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit time; the gap advances on it |
| carrier | input | 1 | Carrier sense from the PHY (asynchronous) |
| full_duplex | input | 1 | 1 selects full-duplex mode, 0 selects half-duplex mode |
| gap_len | input | CNT_W | Gap length in ticks for full-duplex mode |
| part1_len | input | CNT_W | Length in ticks of the resettable first part of the gap (half-duplex mode) |
| tx_done | input | 1 | Pulse at the last bit of the block's own frame |
| tx_begin | input | 1 | Pulse when the transmitter starts a frame |
| frame_pending | input | 1 | Client has a frame ready to send |
| defer | output | 1 | Transmission must be held off |
| tx_permit | output | 1 | Transmission may start now |

## Verification
A wrong gap count appears as `tx_permit` rising one or more ticks early or late. The bench brackets each gap: it checks for no permit one tick before the expected end and for a permit one tick after it. A wrongly kept or wrongly cleared part-one count shows as a permit that arrives after the original count, when it should come after a full gap measured from the second carrier fall, or the reverse. A stuck state, such as staying in transmit or ignoring the duplex select, shows within three clocks as a `defer` or `tx_permit` value that does not match the requirement.

// File: rtl/ifg_defer_pkg.sv
package ifg_defer_pkg;
  typedef enum logic [1:0] {
    ST_BUSY = 2'd0,
    ST_GAP  = 2'd1,
    ST_OPEN = 2'd2,
    ST_TX   = 2'd3
  } ifg_state_e;
endpackage

// File: rtl/ifg_sync_bit.sv
module ifg_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ifg_tick_counter.sv
module ifg_tick_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         tick,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clear)              count <= '0;
    else if (tick && count != MAXV) count <= count + 1'b1;
  end
endmodule

// File: rtl/ifg_defer_timer.sv
module ifg_defer_timer
  import ifg_defer_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int HALF_GAP    = 96,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             carrier,
  input  logic             full_duplex,
  input  logic [CNT_W-1:0] gap_len,
  input  logic [CNT_W-1:0] part1_len,
  input  logic             tx_done,
  input  logic             tx_begin,
  input  logic             frame_pending,
  output logic             defer,
  output logic             tx_permit
);
  localparam logic [CNT_W-1:0] HALF_GAP_V = CNT_W'(HALF_GAP);

  ifg_state_e       state_q, state_n;
  logic             crs_s, crs_d;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;
  logic             cnt_clear, cnt_tick;
  logic             in_part1, gap_done, crs_rise;

  ifg_sync_bit #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(carrier), .dout(crs_s)
  );

  always_ff @(posedge clk) begin
    if (rst) crs_d <= 1'b0;
    else     crs_d <= crs_s;
  end

  ifg_tick_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(cnt_clear), .tick(cnt_tick), .count(cnt)
  );

  assign target   = full_duplex ? gap_len : HALF_GAP_V;
  assign in_part1 = !full_duplex && (cnt < part1_len);
  assign gap_done = cnt >= target;
  assign crs_rise = crs_s && !crs_d;
  assign cnt_tick = (state_q == ST_GAP) && bit_tick;

  always_comb begin
    state_n   = state_q;
    cnt_clear = 1'b0;
    unique case (state_q)
      ST_BUSY: begin
        cnt_clear = 1'b1;
        if (full_duplex || !crs_s) state_n = ST_GAP;
      end
      ST_GAP: begin
        if (in_part1 && crs_s) begin
          state_n   = ST_BUSY;
          cnt_clear = 1'b1;
        end else if (gap_done) begin
          state_n = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (tx_begin && frame_pending)           state_n = ST_TX;
        else if (!full_duplex && crs_rise)       state_n = ST_BUSY;
      end
      ST_TX: begin
        cnt_clear = 1'b1;
        if (tx_done) state_n = ST_GAP;
      end
      default: state_n = ST_GAP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_GAP;
      defer     <= 1'b1;
      tx_permit <= 1'b0;
    end else begin
      state_q   <= state_n;
      defer     <= (state_n != ST_OPEN);
      tx_permit <= (state_n == ST_OPEN) && frame_pending;
    end
  end

  // R2: a permit is only given for a frame that was pending
  a_r2_permit_needs_pending: assert property (@(posedge clk) disable iff (rst)
    tx_permit |-> $past(frame_pending));

  // R3: held carrier in half-duplex keeps the block deferring
  a_r3_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BUSY && !full_duplex && crs_s) |=> (state_q == ST_BUSY));

  // R5: every new gap begins from a cleared count
  a_r5_gap_starts_zero: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_GAP) |=> (state_q == ST_GAP) -> (cnt == '0));

  // R6: second part of the gap cannot be restarted by carrier
  a_r6_part2_no_restart: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GAP && !full_duplex && cnt >= part1_len) |=> (state_q != ST_BUSY));

  // R10: carrier never forces a deferral in full-duplex mode
  a_r10_full_ignores_crs: assert property (@(posedge clk) disable iff (rst)
    (full_duplex && state_q != ST_BUSY) |=> (state_q != ST_BUSY));

  // R8: no permit while the own frame is in progress
  a_r8_tx_no_permit: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TX) |-> (!tx_permit && defer));
endmodule

// File: tb/tb_ifg_defer_timer.sv
module tb_ifg_defer_timer;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst, bit_tick, carrier, full_duplex, tx_done, tx_begin, frame_pending;
  logic [CNT_W-1:0] gap_len, part1_len;
  logic defer, tx_permit;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ifg_defer_timer #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .carrier(carrier),
    .full_duplex(full_duplex), .gap_len(gap_len), .part1_len(part1_len),
    .tx_done(tx_done), .tx_begin(tx_begin), .frame_pending(frame_pending),
    .defer(defer), .tx_permit(tx_permit)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
    end
    settle(3);
  endtask

  task automatic pulse_begin();
    @(negedge clk) tx_begin = 1'b1;
    @(negedge clk) tx_begin = 1'b0;
    settle(3);
  endtask

  task automatic pulse_done();
    @(negedge clk) tx_done = 1'b1;
    @(negedge clk) tx_done = 1'b0;
    settle(3);
  endtask

  task automatic set_crs(input logic v);
    @(negedge clk) carrier = v;
    settle(5);
  endtask

  task automatic t_reset_gap();
    rst = 1'b1; bit_tick = 0; carrier = 0; full_duplex = 0; tx_done = 0;
    tx_begin = 0; frame_pending = 1; gap_len = 8'd96; part1_len = 8'd64;
    settle(4);
    chk("R1", "defer in reset", defer, 1'b1);
    chk("R1", "permit in reset", tx_permit, 1'b0);
    rst = 1'b0;
    ticks(95);
    chk("R1", "permit before first gap", tx_permit, 1'b0);
    ticks(1);
    chk("R1", "permit after first gap", tx_permit, 1'b1);
  endtask

  task automatic t_pending();
    frame_pending = 1'b0; settle(3);
    chk("R2", "permit without frame", tx_permit, 1'b0);
    chk("R2", "defer without frame", defer, 1'b0);
    frame_pending = 1'b1; settle(3);
    chk("R2", "permit with frame", tx_permit, 1'b1);
  endtask

  task automatic t_own_tx();
    pulse_begin();
    chk("R8", "permit after begin", tx_permit, 1'b0);
    chk("R8", "defer after begin", defer, 1'b1);
    ticks(100);
    chk("R8", "permit during own frame", tx_permit, 1'b0);
    pulse_done();
    ticks(95);
    chk("R8", "permit before gap after done", tx_permit, 1'b0);
    ticks(1);
    chk("R8", "permit after gap after done", tx_permit, 1'b1);
  endtask

  task automatic t_carrier();
    set_crs(1'b1);
    chk("R3", "defer with carrier", defer, 1'b1);
    ticks(120);
    chk("R3", "permit with long carrier", tx_permit, 1'b0);
    set_crs(1'b0);
    ticks(95);
    settle(20);
    chk("R4", "idle cycles do not count", tx_permit, 1'b0);
    ticks(1);
    chk("R4", "permit at gap end", tx_permit, 1'b1);
  endtask

  task automatic t_part1();
    set_crs(1'b1); set_crs(1'b0);
    ticks(30);
    set_crs(1'b1); set_crs(1'b0);
    ticks(95);
    chk("R5", "restart in part one", tx_permit, 1'b0);
    ticks(1);
    chk("R5", "permit after restarted gap", tx_permit, 1'b1);
  endtask

  task automatic t_part2();
    set_crs(1'b1); set_crs(1'b0);
    ticks(70);
    set_crs(1'b1);
    ticks(25);
    chk("R6", "permit before gap end", tx_permit, 1'b0);
    ticks(1);
    chk("R6", "carrier in part two ignored", tx_permit, 1'b1);
    set_crs(1'b0);
  endtask

  task automatic t_part1_zero();
    part1_len = 8'd0;
    set_crs(1'b1); set_crs(1'b0);
    set_crs(1'b1);
    ticks(95);
    chk("R7", "permit before gap end", tx_permit, 1'b0);
    ticks(1);
    chk("R7", "no resettable part", tx_permit, 1'b1);
    set_crs(1'b0);
    part1_len = 8'd64;
  endtask

  task automatic t_full();
    full_duplex = 1'b1; gap_len = 8'd12;
    pulse_begin();
    pulse_done();
    set_crs(1'b1);
    ticks(11);
    chk("R9", "permit before full gap", tx_permit, 1'b0);
    ticks(1);
    chk("R9", "permit after full gap", tx_permit, 1'b1);
    set_crs(1'b0); set_crs(1'b1);
    chk("R10", "carrier rise ignored", tx_permit, 1'b1);
    chk("R10", "no defer from carrier", defer, 1'b0);
    set_crs(1'b0);
  endtask

  initial begin
    t_reset_gap();
    t_pending();
    t_own_tx();
    t_carrier();
    t_part1();
    t_part2();
    t_part1_zero();
    t_full();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule